// File: doc/BRIEF.md
# Selectable-Window Rounding Normalizer

This block reduces a 40-bit signed accumulator result to a 16-bit output word. A 4-bit select code picks one of nine 16-bit windows. The windows slide upward one bit per code, starting at bits 31:16. Every code of 8 or more maps to the top window, bits 39:24. When rounding is enabled, the block adds half of the chosen window's LSB to the accumulator value before it takes the window. When rounding is off, the window is a plain truncation.

The select code and the rounding enable sit in a 5-bit control register. A write strobe loads this register. The datapath reads it only on a cycle that carries a valid input, so a control change takes effect from the next valid word on. The output word and its active-low valid flag leave the block from one register stage.

Top module: `rnd_window_norm`

## Requirements
- R1: After reset, `word_out` is 0 and `word_vld_n` is 1. The control register is 0, which selects window bits 31:16 with rounding disabled.
- R2: The control register is loaded from `cfg_in` on a clock edge where `cfg_we` is 1. Bits 3:0 are the window select and bit 4 is the rounding enable.
- R3: For a select code n from 0 to 7, the output word is bits [31+n:16+n] of the (possibly rounded) value.
- R4: For any select code from 8 to 15 (bit 3 set), the output word is bits [39:24].
- R5: With rounding disabled, the output is the selected window of the input, taken without any addition.
- R6: With rounding enabled, the value 1 << (15+n) is added before the window is taken, where n is the select code for codes 0 to 7. For codes 8 to 15 the value is 1 << 23.
- R7: The rounding sum is formed without overflow and is then cut back to 40 bits. A carry out of bit 39 is dropped, and a sum that crosses from positive to negative keeps its 40-bit wrapped bits.
- R8: An input with `in_vld_n` low produces its word on `word_out` and a low `word_vld_n` one clock edge later. An edge with `in_vld_n` high leaves `word_vld_n` high after it.
- R9: `word_out` holds its value across edges where `in_vld_n` is high.
- R10: A control write on the same edge as a valid input does not affect that input's word. It applies from the next valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_in | input | 40 | Signed accumulator result |
| in_vld_n | input | 1 | Input valid, active low |
| cfg_we | input | 1 | Control register write strobe |
| cfg_in | input | 5 | Control value: bit 4 rounding enable, bits 3:0 window select |
| word_out | output | 16 | Normalized output word |
| word_vld_n | output | 1 | Output valid, active low |

## Verification
Every result of the block appears exactly one rising edge after the input that causes it. This applies to the word, its valid flag and the effect of a control write.

The bench changes inputs on the falling edge, lets a single rising edge pass, and reads the outputs at the next falling edge. It never reads them in the middle of the pipeline.

A control write is given its own edge before any valid input that depends on it. The exception is the same-edge test, which expects the old setting on that word and the new setting on the following one.

// File: rtl/norm_pkg.sv
package norm_pkg;
  localparam int SEL_W = 4;
  localparam int CFG_W = SEL_W + 1;

  typedef struct packed {
    logic             rnd_en;
    logic [SEL_W-1:0] sel;
  } norm_cfg_t;
endpackage

// File: rtl/norm_cfg_reg.sv
module norm_cfg_reg
  import norm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  norm_cfg_t d,
  output norm_cfg_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/norm_round.sv
module norm_round #(
  parameter int ACC_W = 40,
  parameter int BASE  = 16,
  parameter int N_WIN = 9,
  parameter int SEL_W = 4
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  output logic [ACC_W-1:0] sum,
  output logic             carry
);
  localparam int SUM_W = ACC_W + 1;

  function automatic int win_idx(input logic [SEL_W-1:0] s);
    return (int'(s) >= N_WIN - 1) ? N_WIN - 1 : int'(s);
  endfunction

  function automatic logic [SUM_W-1:0] half_lsb(input logic [SEL_W-1:0] s,
                                                input logic e);
    logic [SUM_W-1:0] h;
    h = '0;
    if (e) h[BASE - 1 + win_idx(s)] = 1'b1;
    return h;
  endfunction

  logic [SUM_W-1:0] wide;

  always_comb begin
    wide  = {1'b0, acc} + half_lsb(sel, en);
    sum   = wide[ACC_W-1:0];
    carry = wide[ACC_W];
  end
endmodule

// File: rtl/norm_window.sv
module norm_window #(
  parameter int ACC_W = 40,
  parameter int OUT_W = 16,
  parameter int BASE  = 16,
  parameter int N_WIN = 9,
  parameter int SEL_W = 4
) (
  input  logic [ACC_W-1:0] val,
  input  logic [SEL_W-1:0] sel,
  output logic [OUT_W-1:0] word
);
  logic [OUT_W-1:0] cand [N_WIN];

  for (genvar k = 0; k < N_WIN; k++) begin : g_win
    assign cand[k] = val[BASE+k +: OUT_W];
  end

  always_comb begin
    word = cand[N_WIN-1];
    for (int k = 0; k < N_WIN - 1; k++)
      if (int'(sel) == k) word = cand[k];
  end
endmodule

// File: rtl/rnd_window_norm.sv
module rnd_window_norm
  import norm_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int OUT_W = 16,
  parameter int BASE  = 16,
  parameter int N_WIN = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc_in,
  input  logic             in_vld_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_in,
  output logic [OUT_W-1:0] word_out,
  output logic             word_vld_n
);
  localparam int TOP_BIT = BASE + N_WIN - 1 + OUT_W - 1;

  norm_cfg_t        cfg_q;
  logic [ACC_W-1:0] rnd_val;
  logic             rnd_carry;
  logic [OUT_W-1:0] win_word;
  logic             take_word;

  if (TOP_BIT > ACC_W - 1) begin : g_bad_param
    initial $error("window range exceeds accumulator width");
  end

  norm_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .d(norm_cfg_t'(cfg_in)), .q(cfg_q)
  );

  norm_round #(.ACC_W(ACC_W), .BASE(BASE), .N_WIN(N_WIN), .SEL_W(SEL_W)) u_rnd (
    .acc(acc_in), .sel(cfg_q.sel), .en(cfg_q.rnd_en),
    .sum(rnd_val), .carry(rnd_carry)
  );

  norm_window #(.ACC_W(ACC_W), .OUT_W(OUT_W), .BASE(BASE), .N_WIN(N_WIN),
                .SEL_W(SEL_W)) u_win (
    .val(rnd_val), .sel(cfg_q.sel), .word(win_word)
  );

  assign take_word = ~in_vld_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out   <= '0;
      word_vld_n <= 1'b1;
    end else begin
      word_vld_n <= in_vld_n;
      if (take_word) word_out <= win_word;
    end
  end
endmodule

// File: rtl/norm_chk.sv
module norm_chk #(
  parameter int ACC_W = 40,
  parameter int OUT_W = 16,
  parameter int CFG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ACC_W-1:0] acc_in,
  input logic             in_vld_n,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_in,
  input logic [CFG_W-1:0] cfg_q,
  input logic [OUT_W-1:0] word_out,
  input logic             word_vld_n
);
  p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_q == $past(cfg_in));

  p_cfg_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q));

  p_trunc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_vld_n && cfg_q == '0) |=> word_out == $past(acc_in[31:16]));

  p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld_n |=> !word_vld_n);

  p_idle_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld_n |=> word_vld_n);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld_n |=> $stable(word_out));
endmodule

bind rnd_window_norm norm_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W),
                                .CFG_W(norm_pkg::CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .in_vld_n(in_vld_n),
  .cfg_we(cfg_we), .cfg_in(cfg_in), .cfg_q(cfg_q), .word_out(word_out),
  .word_vld_n(word_vld_n)
);

// File: tb/test_rnd_window_norm.sv
module test_rnd_window_norm;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 14;

  // cfg = {round_en, sel[3:0]}
  localparam logic [4:0]  V_CFG [NV] = '{5'h00, 5'h10, 5'h10, 5'h01, 5'h08,
    5'h0F, 5'h18, 5'h1F, 5'h07, 5'h17, 5'h18, 5'h10, 5'h04, 5'h14};
  localparam logic [39:0] V_ACC [NV] = '{40'h00_1234_5678, 40'h00_1234_8000,
    40'h00_1234_7FFF, 40'h00_2468_ACF0, 40'hAB_CD12_3456, 40'hAB_CD12_3456,
    40'hAB_CD80_0000, 40'hAB_CD7F_FFFF, 40'h12_3456_7890, 40'h12_3456_7890,
    40'h7F_FFFF_FFFF, 40'hFF_FFFF_8000, 40'h01_2345_6789, 40'h01_2348_0000};
  localparam logic [15:0] V_EXP [NV] = '{16'h1234, 16'h1235, 16'h1234,
    16'h1234, 16'hABCD, 16'hABCD, 16'hABCE, 16'hABCD, 16'h2468, 16'h2469,
    16'h8000, 16'h0000, 16'h1234, 16'h1235};
  localparam string V_REQ [NV] = '{"R5", "R6", "R6", "R3", "R4", "R4", "R6",
    "R6", "R3", "R6", "R7", "R7", "R3", "R6"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] acc_in = '0;
  logic        in_vld_n = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_in = '0;
  logic [15:0] word_out;
  logic        word_vld_n;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  rnd_window_norm i_rnd_window_norm (
    .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .in_vld_n(in_vld_n),
    .cfg_we(cfg_we), .cfg_in(cfg_in), .word_out(word_out),
    .word_vld_n(word_vld_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cyc);
      finish_run();
    end
  end

  task automatic write_cfg(input logic [4:0] v);
    cfg_in = v;
    cfg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [39:0] a);
    acc_in   = a;
    in_vld_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_vld_n = 1'b1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1", 32'(word_out), 32'h0);
    check("R1", 32'(word_vld_n), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset control value selects 31:16, no rounding
    push(40'hAB_CD12_8000);
    check("R1", 32'(word_out), 32'hCD12);
    check("R8", 32'(word_vld_n), 32'h0);
    @(negedge clk);
    check("R8", 32'(word_vld_n), 32'h1);
    check("R9", 32'(word_out), 32'hCD12);

    for (int i = 0; i < NV; i++) begin
      write_cfg(V_CFG[i]);
      check("R2", 32'(word_out), 32'(i == 0 ? 16'hCD12 : V_EXP[i-1]));
      push(V_ACC[i]);
      check(V_REQ[i], 32'(word_out), 32'(V_EXP[i]));
    end

    // R9: idle edges with changing acc_in leave the word alone
    acc_in = 40'h55_5555_5555;
    repeat (3) @(negedge clk);
    check("R9", 32'(word_out), 32'(V_EXP[NV-1]));

    // R10: write on the same edge as a valid input
    write_cfg(5'h00);
    acc_in   = 40'hAB_CD12_3456;
    in_vld_n = 1'b0;
    cfg_in   = 5'h08;
    cfg_we   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    check("R10", 32'(word_out), 32'hCD12);
    check("R8", 32'(word_vld_n), 32'h0);
    @(posedge clk);
    @(negedge clk);
    in_vld_n = 1'b1;
    check("R10", 32'(word_out), 32'hABCD);

    // R8: back-to-back valid inputs
    write_cfg(5'h00);
    acc_in   = 40'h00_1111_0000;
    in_vld_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R8", 32'(word_out), 32'h1111);
    acc_in = 40'h00_2222_0000;
    @(posedge clk);
    @(negedge clk);
    in_vld_n = 1'b1;
    check("R8", 32'(word_out), 32'h2222);
    check("R8", 32'(word_vld_n), 32'h0);

    // R1: reset mid-run clears the output and the control register
    write_cfg(5'h1F);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 32'(word_out), 32'h0);
    check("R1", 32'(word_vld_n), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    push(40'hAB_CD12_8000);
    check("R1", 32'(word_out), 32'hCD12);

    finish_run();
  end
endmodule